// File: doc/BRIEF.md
# Relocation and Bounds Check Unit

This block sits between a processor's address generator and the memory request path. Every logical address that the running process issues is first compared with a programmed size (the limit). An address is accepted only when it is strictly below that size. An accepted address is then offset by a programmed relocation base, which gives the physical address sent to memory. An address that is out of range, or whose relocated value would not fit in the physical address width, produces a protection fault instead. The fault reports the offending logical address and never the physical address.

Base and limit are loaded through a small write port. The write port is honoured only while the supervisor-mode input is high. A write attempted in user mode changes nothing and raises a privilege-error pulse. Both registers clear on reset, so every access faults until software has programmed them. With `REG_OUT=1` (the default) each result is registered one cycle after its request. With `REG_OUT=0` the result appears combinationally in the same cycle.

Top module: `reloc_limit_unit`

## Requirements
- R1: After reset, base and limit are zero, `mem_valid`, `flt_valid` and `priv_err` are low, and any request (including logical address 0) faults.
- R2: A request whose logical address is strictly below the limit gives `mem_valid` high for one cycle, with `mem_paddr` equal to base plus the logical address, zero-extended.
- R3: A request whose logical address is equal to or above the limit gives `flt_valid` high for one cycle, with `flt_laddr` equal to the logical address and `mem_paddr` equal to zero.
- R4: The range check uses the logical address, never the relocated one. A small logical address is legal under a small limit even when the base makes its physical address numerically larger than the limit.
- R5: When base plus the logical address exceeds the largest value that `PA_W` bits can hold, the request faults, even if the address is within the limit.
- R6: A write with `cfg_we` high and `priv_mode` high loads `cfg_wdata` into the base register when `cfg_sel` is 0. When `cfg_sel` is 1 it loads the low `LA_W+1` bits into the limit register. Requests sampled on any later clock edge use the new value.
- R7: A write with `cfg_we` high and `priv_mode` low leaves base and limit unchanged. It drives `priv_err` high for exactly the cycle after the write edge.
- R8: In a cycle with no request, the next result cycle has `mem_valid` and `flt_valid` both low.
- R9: Each request produces exactly one of `mem_valid` or `flt_valid`, never both. Back-to-back requests are each answered in their own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_mode | input | 1 | High when the requester runs in supervisor mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 base, 1 limit |
| cfg_wdata | input | PA_W | Write data |
| priv_err | output | 1 | One-cycle pulse after a user-mode write attempt |
| req_valid | input | 1 | Access strobe for the logical address |
| req_laddr | input | LA_W | Logical address |
| mem_valid | output | 1 | Translated request valid |
| mem_paddr | output | PA_W | Physical address; zero unless mem_valid |
| flt_valid | output | 1 | Protection fault pulse |
| flt_laddr | output | LA_W | Faulting logical address; zero unless flt_valid |

## Verification
With the default registered output, a request driven before clock edge k is answered in the cycle that follows edge k. A register write at edge k is already in force for a request sampled at edge k+1, and `priv_err` rises after the write edge and falls after the next one. The bench drives inputs on the falling edge and samples one nanosecond after the rising edge that should produce each result. It compares against a base/limit model that it keeps from its own writes. Back-to-back requests are checked one result per cycle in the same way.

// File: rtl/rlu_pkg.sv
package rlu_pkg;

   // Target of a configuration write
   typedef enum logic {
      RLU_SEL_BASE  = 1'b0,
      RLU_SEL_LIMIT = 1'b1
   } rlu_sel_e;

   // Outcome of one translation, used by the response stage
   typedef enum logic [1:0] {
      RLU_IDLE  = 2'b00,
      RLU_GRANT = 2'b01,
      RLU_FAULT = 2'b10
   } rlu_outcome_e;

endpackage

// File: rtl/rlu_cfg_regs.sv
module rlu_cfg_regs
   import rlu_pkg::*;
#(
   parameter int PA_W  = 20,
   parameter int LIM_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             priv_mode,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [PA_W-1:0]  cfg_wdata,
   output logic [PA_W-1:0]  base_q,
   output logic [LIM_W-1:0] limit_q,
   output logic             priv_err_q
);

   generate
      if (LIM_W > PA_W) begin : g_bad_width
         $error("rlu_cfg_regs: limit wider than write data");
      end
   endgenerate

   logic     wr_ok;
   logic     wr_bad;
   rlu_sel_e sel;

   assign sel    = rlu_sel_e'(cfg_sel);
   assign wr_ok  = cfg_we &  priv_mode;
   assign wr_bad = cfg_we & ~priv_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (wr_ok && sel == RLU_SEL_BASE) begin
         base_q <= cfg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= '0;
      end else if (wr_ok && sel == RLU_SEL_LIMIT) begin
         limit_q <= cfg_wdata[LIM_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) priv_err_q <= 1'b0;
      else        priv_err_q <= wr_bad;
   end

   AST_USER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !priv_mode) |=> ($stable(base_q) && $stable(limit_q))); // R7

   AST_PRIV_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      priv_err_q |-> $past(cfg_we && !priv_mode)); // R7

endmodule

// File: rtl/rlu_xlate.sv
module rlu_xlate #(
   parameter int LA_W  = 16,
   parameter int PA_W  = 20,
   parameter int LIM_W = 17
) (
   input  logic [LA_W-1:0]  laddr,
   input  logic [PA_W-1:0]  base,
   input  logic [LIM_W-1:0] limit,
   output logic             legal,
   output logic [PA_W-1:0]  paddr
);

   localparam int SUM_W = PA_W + 1;

   logic [PA_W-1:0]  laddr_ext;
   logic [LIM_W-1:0] laddr_cmp;
   logic [SUM_W-1:0] sum;
   logic             in_range;
   logic             wrap;

   // Widen the logical address to the physical width
   generate
      if (PA_W > LA_W) begin : g_pad
         assign laddr_ext = {{(PA_W-LA_W){1'b0}}, laddr};
      end else begin : g_same
         assign laddr_ext = laddr;
      end
   endgenerate

   assign laddr_cmp = {{(LIM_W-LA_W){1'b0}}, laddr};

   // Bounds test on the logical address, strictly below the limit
   assign in_range = (laddr_cmp < limit);

   // Relocation with carry-out kept to flag a wrap past the top
   assign sum   = {1'b0, base} + {1'b0, laddr_ext};
   assign wrap  = sum[PA_W];
   assign paddr = sum[PA_W-1:0];
   assign legal = in_range & ~wrap;

endmodule

// File: rtl/rlu_resp.sv
module rlu_resp
   import rlu_pkg::*;
#(
   parameter int LA_W    = 16,
   parameter int PA_W    = 20,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [LA_W-1:0] req_laddr,
   input  logic            legal,
   input  logic [PA_W-1:0] paddr,
   output logic            mem_valid_o,
   output logic [PA_W-1:0] mem_paddr_o,
   output logic            flt_valid_o,
   output logic [LA_W-1:0] flt_laddr_o
);

   rlu_outcome_e    outcome;
   logic [PA_W-1:0] paddr_gated;
   logic [LA_W-1:0] laddr_gated;

   always_comb begin
      if (!req_valid)  outcome = RLU_IDLE;
      else if (legal)  outcome = RLU_GRANT;
      else             outcome = RLU_FAULT;
   end

   // The physical address never leaves the block on a fault
   assign paddr_gated = (outcome == RLU_GRANT) ? paddr     : '0;
   assign laddr_gated = (outcome == RLU_FAULT) ? req_laddr : '0;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_valid_o <= 1'b0;
               flt_valid_o <= 1'b0;
               mem_paddr_o <= '0;
               flt_laddr_o <= '0;
            end else begin
               mem_valid_o <= (outcome == RLU_GRANT);
               flt_valid_o <= (outcome == RLU_FAULT);
               mem_paddr_o <= paddr_gated;
               flt_laddr_o <= laddr_gated;
            end
         end

         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(req_valid) |-> !(mem_valid_o || flt_valid_o)); // R8

         AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
            $past(req_valid) |-> (mem_valid_o ^ flt_valid_o)); // R9

         AST_FLT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
            flt_valid_o |-> (flt_laddr_o == $past(req_laddr))); // R3
      end else begin : g_comb
         assign mem_valid_o = (outcome == RLU_GRANT);
         assign flt_valid_o = (outcome == RLU_FAULT);
         assign mem_paddr_o = paddr_gated;
         assign flt_laddr_o = laddr_gated;
      end
   endgenerate

   AST_FAULT_HIDES_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid_o |-> (mem_paddr_o == '0)); // R3

   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_valid_o && flt_valid_o)); // R9

endmodule

// File: rtl/reloc_limit_unit.sv
module reloc_limit_unit #(
   parameter int LA_W    = 16,
   parameter int PA_W    = 20,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            priv_mode,
   input  logic            cfg_we,
   input  logic            cfg_sel,
   input  logic [PA_W-1:0] cfg_wdata,
   output logic            priv_err,
   input  logic            req_valid,
   input  logic [LA_W-1:0] req_laddr,
   output logic            mem_valid,
   output logic [PA_W-1:0] mem_paddr,
   output logic            flt_valid,
   output logic [LA_W-1:0] flt_laddr
);

   localparam int LIM_W = LA_W + 1;

   generate
      if (LA_W < 1) begin : g_bad_la
         $error("reloc_limit_unit: LA_W must be at least 1");
      end
      if (PA_W < LIM_W) begin : g_bad_pa
         $error("reloc_limit_unit: PA_W must exceed LA_W");
      end
   endgenerate

   logic [PA_W-1:0]  base_q;
   logic [LIM_W-1:0] limit_q;
   logic             legal;
   logic [PA_W-1:0]  paddr;

   rlu_cfg_regs #(.PA_W(PA_W), .LIM_W(LIM_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .priv_mode  (priv_mode),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .base_q     (base_q),
      .limit_q    (limit_q),
      .priv_err_q (priv_err)
   );

   rlu_xlate #(.LA_W(LA_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_xlate (
      .laddr (req_laddr),
      .base  (base_q),
      .limit (limit_q),
      .legal (legal),
      .paddr (paddr)
   );

   rlu_resp #(.LA_W(LA_W), .PA_W(PA_W), .REG_OUT(REG_OUT)) u_resp (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_laddr   (req_laddr),
      .legal       (legal),
      .paddr       (paddr),
      .mem_valid_o (mem_valid),
      .mem_paddr_o (mem_paddr),
      .flt_valid_o (flt_valid),
      .flt_laddr_o (flt_laddr)
   );

   generate
      if (REG_OUT) begin : g_chk_reg
         AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid |-> (mem_paddr >= $past(base_q))); // R5
      end else begin : g_chk_comb
         AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid |-> (mem_paddr >= base_q)); // R5
      end
   endgenerate

endmodule

// File: tb/tb_reloc_limit_unit.sv
module tb_reloc_limit_unit;

   localparam int LA_W = 16;
   localparam int PA_W = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            priv_mode = 1'b0;
   logic            cfg_we = 1'b0;
   logic            cfg_sel = 1'b0;
   logic [PA_W-1:0] cfg_wdata = '0;
   logic            priv_err;
   logic            req_valid = 1'b0;
   logic [LA_W-1:0] req_laddr = '0;
   logic            mem_valid;
   logic [PA_W-1:0] mem_paddr;
   logic            flt_valid;
   logic [LA_W-1:0] flt_laddr;

   int checks = 0;
   int failures = 0;

   // Bench model of the programmed registers
   longint m_base  = 0;
   longint m_limit = 0;

   always #5 clk = ~clk;

   reloc_limit_unit #(.LA_W(LA_W), .PA_W(PA_W), .REG_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .priv_err(priv_err),
      .req_valid(req_valid), .req_laddr(req_laddr), .mem_valid(mem_valid),
      .mem_paddr(mem_paddr), .flt_valid(flt_valid), .flt_laddr(flt_laddr)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Check the result of a request answered at the last rising edge
   task automatic check_result(input longint la, input string tag);
      bit     ok_exp;
      longint pa;
      pa     = m_base + la;
      ok_exp = (la < m_limit) && (pa < (longint'(1) << PA_W));
      chk(mem_valid == ok_exp, {tag, " mem_valid"}, mem_valid, ok_exp);
      chk(flt_valid == !ok_exp, {tag, " flt_valid"}, flt_valid, !ok_exp);
      chk(mem_paddr == (ok_exp ? pa : 0), {tag, " mem_paddr"}, mem_paddr, ok_exp ? pa : 0);
      chk(flt_laddr == (ok_exp ? 0 : la), {tag, " flt_laddr"}, flt_laddr, ok_exp ? 0 : la);
   endtask

   task automatic do_req(input longint la, input string tag);
      @(negedge clk);
      req_valid = 1'b1;
      req_laddr = LA_W'(la);
      @(posedge clk);
      #1;
      check_result(la, tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic cfg_write(input bit sel, input longint data, input bit priv, input string tag);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = PA_W'(data);
      priv_mode = priv;
      @(posedge clk);
      #1;
      chk(priv_err == !priv, {tag, " priv_err pulse"}, priv_err, !priv);
      if (priv) begin
         if (sel) m_limit = data & ((longint'(1) << (LA_W+1)) - 1);
         else     m_base  = data;
      end
      @(negedge clk);
      cfg_we    = 1'b0;
      priv_mode = 1'b0;
      @(posedge clk);
      #1;
      chk(priv_err == 1'b0, {tag, " priv_err one cycle"}, priv_err, 0);
   endtask

   task automatic t_reset();
      chk(mem_valid == 0, "R1 reset mem_valid", mem_valid, 0);
      chk(flt_valid == 0, "R1 reset flt_valid", flt_valid, 0);
      chk(priv_err == 0, "R1 reset priv_err", priv_err, 0);
      do_req(0, "R1 addr0 faults");
      do_req(16'h1234, "R1 any faults");
   endtask

   task automatic t_program();
      cfg_write(1'b1, 32'h1000, 1'b1, "R6 limit write");
      cfg_write(1'b0, 32'h2000, 1'b1, "R6 base write");
      do_req(16'h0000, "R2 low edge");
      do_req(16'h0FFF, "R2 last legal");
      do_req(16'h0123, "R2 mid");
      do_req(16'h1000, "R3 equal limit");
      do_req(16'hFFFF, "R3 far above");
   endtask

   task automatic t_logical();
      cfg_write(1'b1, 32'h100, 1'b1, "R6 small limit");
      cfg_write(1'b0, 32'h30000, 1'b1, "R6 high base");
      do_req(16'h00FF, "R4 logical compare");
      do_req(16'h0100, "R4 logical edge");
   endtask

   task automatic t_overflow();
      cfg_write(1'b1, 32'h10000, 1'b1, "R6 full limit");
      cfg_write(1'b0, 32'hFFFF0, 1'b1, "R6 top base");
      do_req(16'h000F, "R5 top fits");
      do_req(16'h0010, "R5 wrap faults");
      do_req(16'hFFFF, "R5 wrap far");
   endtask

   task automatic t_user();
      cfg_write(1'b0, 32'h12345, 1'b0, "R7 user base");
      cfg_write(1'b1, 32'h00001, 1'b0, "R7 user limit");
      do_req(16'h000A, "R7 regs unchanged");
      do_req(16'h0010, "R7 regs unchanged wrap");
   endtask

   task automatic t_idle();
      @(negedge clk);
      req_valid = 1'b0;
      req_laddr = 16'h0005;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         #1;
         chk(!mem_valid && !flt_valid, "R8 idle quiet", {mem_valid, flt_valid}, 0);
      end
   endtask

   task automatic t_burst();
      longint seq [6] = '{16'h0001, 16'h0010, 16'h0002, 16'h0020, 16'h0003, 16'h000F};
      cfg_write(1'b0, 32'hFFFF0, 1'b1, "R9 base");
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         req_valid = 1'b1;
         req_laddr = LA_W'(seq[i]);
         @(posedge clk);
         #1;
         chk(mem_valid ^ flt_valid, "R9 one outcome", {mem_valid, flt_valid}, 1);
         check_result(seq[i], "R9 burst");
      end
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      #1;
      chk(!mem_valid && !flt_valid, "R9 single cycle", {mem_valid, flt_valid}, 0);
   endtask

   initial begin
      #5000000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset_pre();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program();
      t_logical();
      t_overflow();
      t_user();
      t_idle();
      t_burst();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic t_reset_pre();
      chk(mem_paddr == 0, "R1 reset mem_paddr", mem_paddr, 0);
      chk(flt_laddr == 0, "R1 reset flt_laddr", flt_laddr, 0);
   endtask

endmodule